// File: doc/BRIEF.md
# Buffered Parallel-In Serial-Out Shifter

The block holds a parallel word in a capture register and serializes a separate working copy of it through a shift register. A storage strobe samples the parallel input bus into the capture register. The shift register can be filled from that stored copy, forced to zero, or shifted by one position per shift strobe. Because the shifter loads from the stored copy and not from the pins, the next word can be captured while the current word is still shifting out.

Everything runs on one system clock with a synchronous, active-high reset. The two strobes are single-cycle clock enables. The active-low load and clear controls are level overrides that are sampled on every cycle. The serial output is the most significant stage, so a loaded word leaves MSB first. Bits entering at the serial input fill stage 0. Tying the serial input of one block to the serial output of another chains them into a longer register.

Both data paths are plain per-cycle strobes with no back-pressure. The capture register accepts a word in any cycle its strobe is high. The shifter moves on every enabled cycle whatever state the downstream logic is in, so upstream logic must pace the strobes itself.

Top module: `piso_buffered_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, the capture register and the shift register both become all zeros, so `ser_out` reads 0 after that edge.
- R2: When `cap_stb` is high at an edge, the capture register takes `par_word`. The levels of `load_n`, `clr_n` and `shf_stb` have no effect on this.
- R3: When `cap_stb` is low, the capture register keeps its value whatever `par_word` does.
- R4: When `load_n` is 0 and `clr_n` is 1, the shift register takes the capture register value at that edge. This happens without `shf_stb`, and it overrides a shift even when `shf_stb` is high.
- R5: When `cap_stb` is high in the same cycle as a load (`load_n` 0, `clr_n` 1), the new `par_word` reaches the shift register at that same edge.
- R6: When `clr_n` is 0 and `load_n` is 1, the shift register becomes all zeros. The capture register is left unchanged.
- R7: When `load_n` and `clr_n` are both 1 and `shf_stb` is high, each stage i takes stage i-1 and stage 0 takes `ser_in`.
- R8: When `load_n` and `clr_n` are both 1 and `shf_stb` is low, the shift register holds its value.
- R9: When `load_n` and `clr_n` are both 0, clear takes precedence. The shift register becomes all zeros and the capture register is left unchanged.
- R10: When `cap_stb` and `shf_stb` are high together with no load or clear, the shift uses the previous shift register contents, and the capture register takes the new word at the same edge.
- R11: `ser_out` is stage WIDTH-1 of the shift register. After a load, the word leaves MSB first, one bit per shift strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| par_word | input | WIDTH | Parallel word sampled by the capture register |
| ser_in | input | 1 | Serial fill bit for stage 0 |
| cap_stb | input | 1 | Capture strobe, one-cycle enable |
| shf_stb | input | 1 | Shift strobe, one-cycle enable |
| load_n | input | 1 | Load shifter from capture register, active low, level |
| clr_n | input | 1 | Clear shifter, active low, level |
| ser_out | output | 1 | Last shift stage |

## Verification
Only one bit of the state is visible at the ports, so a wrong stage value shows up on `ser_out` only once enough shift strobes have moved it to the last stage. The delay is up to WIDTH-1 shifts after the fault. A corrupted capture register stays hidden until the next load followed by a full shift-out. The bench therefore reads back every interesting state by shifting out the whole word, and it reloads the capture copy after each clear or simultaneous strobe to show that the copy survived. A cycle-level reference model runs alongside these reads and flags a mismatch on the first cycle the wrong bit reaches the output.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_LOAD  = 2'd2,
    SH_CLEAR = 2'd3
  } sh_op_e;

endpackage

// File: rtl/piso_capture.sv
module piso_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_next
);

  // next value is exposed so a same-cycle load sees the fresh word
  always_comb begin
    q_next = stb ? din : q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic   load_n,
  input  logic   clr_n,
  input  logic   shf_stb,
  output sh_op_e op
);

  // clear beats load, load beats shift
  always_comb begin
    if (!clr_n)        op = SH_CLEAR;
    else if (!load_n)  op = SH_LOAD;
    else if (shf_stb)  op = SH_SHIFT;
    else               op = SH_HOLD;
  end

endmodule

// File: rtl/piso_shift_chain.sv
module piso_shift_chain
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sh_op_e           op,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] load_word,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic src;
    logic d;
    logic stage_q;

    if (i == 0) begin : g_head
      assign src = ser_in;
    end else begin : g_body
      assign src = q[i-1];
    end

    always_comb begin
      unique case (op)
        SH_CLEAR: d = 1'b0;
        SH_LOAD:  d = load_word[i];
        SH_SHIFT: d = src;
        default:  d = stage_q;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) stage_q <= 1'b0;
      else     stage_q <= d;
    end

    assign q[i] = stage_q;
  end

endmodule

// File: rtl/piso_buffered_shifter.sv
module piso_buffered_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_word,
  input  logic             ser_in,
  input  logic             cap_stb,
  input  logic             shf_stb,
  input  logic             load_n,
  input  logic             clr_n,
  output logic             ser_out
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] cap_q;
  logic [WIDTH-1:0] cap_next;
  logic [WIDTH-1:0] sh_q;
  sh_op_e           op;

  piso_capture #(.WIDTH(WIDTH)) cap_i (
    .clk    (clk),
    .rst    (rst),
    .stb    (cap_stb),
    .din    (par_word),
    .q      (cap_q),
    .q_next (cap_next)
  );

  piso_ctrl ctrl_i (
    .load_n  (load_n),
    .clr_n   (clr_n),
    .shf_stb (shf_stb),
    .op      (op)
  );

  piso_shift_chain #(.WIDTH(WIDTH)) chain_i (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .ser_in    (ser_in),
    .load_word (cap_next),
    .q         (sh_q)
  );

  assign ser_out = sh_q[LAST];

endmodule

// File: rtl/piso_buffered_shifter_chk.sv
module piso_buffered_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] par_word,
  input logic             ser_in,
  input logic             cap_stb,
  input logic             shf_stb,
  input logic             load_n,
  input logic             clr_n,
  input logic [WIDTH-1:0] cap_q,
  input logic [WIDTH-1:0] sh_q
);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (cap_q == '0 && sh_q == '0));

  // R2
  capture_take_chk: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> cap_q == $past(par_word));

  // R3
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(cap_q));

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n && clr_n) |=> sh_q == cap_q);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && load_n) |=> sh_q == '0);

  // R9
  both_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !load_n) |=> (sh_q == '0 && $stable(cap_q)));

  // R7
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && clr_n && shf_stb) |=>
      sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)});

  // R8
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && clr_n && !shf_stb) |=> $stable(sh_q));

endmodule

bind piso_buffered_shifter piso_buffered_shifter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .par_word (par_word),
  .ser_in   (ser_in),
  .cap_stb  (cap_stb),
  .shf_stb  (shf_stb),
  .load_n   (load_n),
  .clr_n    (clr_n),
  .cap_q    (cap_q),
  .sh_q     (sh_q)
);

// File: tb/piso_buffered_shifter_tb_top.sv
module piso_buffered_shifter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 14;

  // {par_word, ser_in, cap_stb, shf_stb, load_n, clr_n, expected ser_out}
  localparam logic [13:0] VEC [NVEC] = '{
    {8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 capture only
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 load A5
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R8
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7
    {8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R10
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 load 5A
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R11
    {8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}  // R7
  };

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] par_word;
  logic         ser_in, cap_stb, shf_stb, load_n, clr_n;
  logic         ser_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] cap_m, sh_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_buffered_shifter #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .par_word(par_word), .ser_in(ser_in),
    .cap_stb(cap_stb), .shf_stb(shf_stb), .load_n(load_n),
    .clr_n(clr_n), .ser_out(ser_out)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_out=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, sample at next negedge
  task automatic tick(input logic [W-1:0] p, input logic s, input logic c,
                      input logic f, input logic ld, input logic cl);
    logic [W-1:0] cn;
    par_word = p; ser_in = s; cap_stb = c; shf_stb = f; load_n = ld; clr_n = cl;
    @(posedge clk);
    cn = c ? p : cap_m;
    if (!cl)      sh_m = '0;
    else if (!ld) sh_m = cn;
    else if (f)   sh_m = {sh_m[W-2:0], s};
    cap_m = cn;
    @(negedge clk);
    check(ser_out, sh_m[W-1], "R11 model");
  endtask

  task automatic idle_drive();
    par_word = '0; ser_in = 1'b0; cap_stb = 1'b0; shf_stb = 1'b0;
    load_n = 1'b1; clr_n = 1'b1;
  endtask

  task automatic do_reset();
    idle_drive();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cap_m = '0; sh_m = '0;
  endtask

  // reads the whole shifter MSB first through ser_out
  task automatic read_word(input logic [W-1:0] exp, input string tag);
    for (int i = W-1; i >= 0; i--) begin
      check(ser_out, exp[i], tag);
      if (i > 0) tick('0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0] bits;
    rst = 1'b1;
    idle_drive();
    @(negedge clk);
    do_reset();

    // R1: reset state
    check(ser_out, 1'b0, "R1 after reset");
    tick('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    read_word(8'h00, "R1 capture zero");

    // R5: same-cycle capture and load
    tick(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    read_word(8'hA5, "R5 passthrough");

    // R2 capture during clear with shift strobe; R6 clear
    tick(8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    check(ser_out, 1'b0, "R6 cleared");
    read_word(8'h00, "R6 cleared word");
    // R3: par_word changes without strobe
    tick(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    read_word(8'h3C, "R2 R3 captured under clear");

    // R4: load held with shift strobe active
    for (int k = 0; k < 3; k++) begin
      tick(8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      check(ser_out, 1'b0, "R4 load overrides shift");
    end
    read_word(8'h3C, "R4 load word");

    // R7: shift in serial pattern while old word leaves
    tick('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    bits = 8'b1011_0010;
    for (int i = W-1; i >= 0; i--) begin
      check(ser_out, W'(8'h3C) >> i, "R7 old word out");
      tick('0, bits[i], 1'b0, 1'b1, 1'b1, 1'b1);
    end
    read_word(bits, "R7 serial fill");

    // R8: hold without shift strobe
    tick('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      tick(8'hFF, k[0], 1'b0, 1'b0, 1'b1, 1'b1);
      check(ser_out, 1'b0, "R8 hold");
    end
    read_word(8'h3C, "R8 word intact");

    // R10: capture and shift together
    tick(8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    tick(8'h7E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    read_word(8'h03, "R10 shift used old contents");
    tick('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    read_word(8'h7E, "R10 capture took new word");

    // R9: both controls low, clear wins, capture kept
    tick(8'h11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check(ser_out, 1'b0, "R9 clear wins");
    read_word(8'h00, "R9 cleared word");
    tick('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    read_word(8'h7E, "R9 capture kept");

    // R1: reset in mid-operation
    tick(8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    do_reset();
    check(ser_out, 1'b0, "R1 mid-run reset");
    tick('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    read_word(8'h00, "R1 capture cleared by reset");

    // vector table, from a fresh reset
    do_reset();
    for (int v = 0; v < NVEC; v++) begin
      tick(VEC[v][13:6], VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1]);
      check(ser_out, VEC[v][0], $sformatf("R11 table row %0d", v));
    end

    // random legal sequences against the model
    for (int r = 0; r < 400; r++) begin
      logic ld, cl;
      ld = ($urandom_range(0, 4) != 0);
      cl = ($urandom_range(0, 6) != 0);
      if (!ld && !cl) cl = 1'b1;
      tick(W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), ld, cl);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule